// File: doc/BRIEF.md
# Power-Down Sequencer

This block sequences a memory macro into and out of a data-retaining low-power state. The request input is active high and asynchronous to the clock. The block first passes it through a flop synchroniser. It then runs a timed entry phase before it reports the sleep state. When the request falls, it runs a timed recovery phase before normal accesses are allowed again.

From the moment the synchronised request is seen, until recovery has finished, the block blocks new accesses. Any access that was in flight is dropped, not completed. The data drivers are held disabled whenever the block is not fully awake. Stored contents must survive the whole sequence, so any access attempt while blocked is a protocol violation. The block flags such an attempt and does not act on it. Here an access attempt means the combined select or either address strobe going active.

The actual power gating sits outside this block. It consumes the `sleep_o` and `out_disable_o` outputs.

Top module: `pdn_sequencer`

## Requirements
- R1: While reset is high and on the first cycle after it, all four outputs are low and the block is awake.
- R2: A change on `pdn_req_async` is seen internally SYNC_STAGES rising edges after it is first sampled; nothing reacts earlier.
- R3: Once the synchronised request is high in the awake state, the block spends exactly ENTRY_CYC cycles entering; `sleep_o` rises ENTRY_CYC+1 edges after `access_block_o` rises.
- R4: Once the synchronised request is low while asleep, the block spends exactly EXIT_CYC cycles recovering. `access_block_o` falls SYNC_STAGES+1+EXIT_CYC edges after the request falls is first sampled.
- R5: `out_disable_o` is high in every cycle in which the block is entering, asleep or recovering, and low only when awake.
- R6: `access_block_o` is high when the block is not awake, or when it is awake with the synchronised request high; it is low otherwise.
- R7: A cycle in which `access_block_o` is high and any of `sel_active`, `strobe_a`, `strobe_b` is high produces `violation_o` high on the following cycle only. Such an attempt never changes the state sequence.
- R8: Select or strobe activity while `access_block_o` is low never raises `violation_o`.
- R9: A request that falls after entry has begun does not abort entry: sleep is reached, then recovery follows.
- R10: A request that rises again during recovery does not cut recovery short: the block is awake for exactly one cycle, then re-enters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pdn_req_async | input | 1 | Asynchronous low-power request, active high |
| sel_active | input | 1 | Combined chip select, active high |
| strobe_a | input | 1 | First address strobe, active high |
| strobe_b | input | 1 | Second address strobe, active high |
| sleep_o | output | 1 | High while in the low-power state |
| access_block_o | output | 1 | High while new accesses are refused |
| out_disable_o | output | 1 | High while the data drivers must stay off |
| violation_o | output | 1 | One-cycle flag for an access attempt while blocked |

## Verification
The bench builds the block with SYNC_STAGES=2, ENTRY_CYC=2 and EXIT_CYC=3. Because the entry and exit windows then have different lengths, a swapped counter load or an off-by-one in either window shows up as a wrong edge count. With two synchroniser stages, an early reaction to the raw request is visible as a cycle skew. A reference model in the bench is compared with all four outputs on every clock. The scenarios cover attempts in each phase, a request dropped during entry, and a request raised again during recovery.

// File: rtl/pdn_pkg.sv
package pdn_pkg;

    typedef enum logic [1:0] {
        PS_AWAKE  = 2'd0,
        PS_ENTER  = 2'd1,
        PS_ASLEEP = 2'd2,
        PS_WAKE   = 2'd3
    } pdn_state_e;

    typedef struct packed {
        logic sleep;
        logic block;
        logic odis;
    } pdn_status_t;

    function automatic int cnt_width(input int a, input int b);
        int m;
        m = (a > b) ? a : b;
        return (m > 2) ? $clog2(m) : 1;
    endfunction

    function automatic pdn_status_t decode_status(input pdn_state_e st, input logic req);
        pdn_status_t s;
        s.sleep = (st == PS_ASLEEP);
        s.odis  = (st != PS_AWAKE);
        s.block = (st != PS_AWAKE) || req;
        return s;
    endfunction

endpackage

// File: rtl/pdn_sync.sv
module pdn_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= d_async;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], d_async};
            end
        end
    endgenerate

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/pdn_fsm.sv
module pdn_fsm
    import pdn_pkg::*;
#(
    parameter int ENTRY_CYC = 2,
    parameter int EXIT_CYC  = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       req_i,
    output pdn_state_e state_o
);
    localparam int CW = cnt_width(ENTRY_CYC, EXIT_CYC);
    localparam logic [CW-1:0] ENT_LD = CW'(ENTRY_CYC - 1);
    localparam logic [CW-1:0] EXT_LD = CW'(EXIT_CYC - 1);

    pdn_state_e    state, state_n;
    logic [CW-1:0] cnt, cnt_n;

    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        unique case (state)
            PS_AWAKE: if (req_i) begin
                state_n = PS_ENTER;
                cnt_n   = ENT_LD;
            end
            PS_ENTER: begin
                if (cnt == '0) state_n = PS_ASLEEP;
                else           cnt_n   = cnt - 1'b1;
            end
            PS_ASLEEP: if (!req_i) begin
                state_n = PS_WAKE;
                cnt_n   = EXT_LD;
            end
            PS_WAKE: begin
                if (cnt == '0) state_n = PS_AWAKE;
                else           cnt_n   = cnt - 1'b1;
            end
            default: state_n = PS_AWAKE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= PS_AWAKE;
            cnt   <= '0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
        end
    end

    assign state_o = state;

    assert_enter_window_R3: assert property (@(posedge clk) disable iff (rst)
        ($past(state) == PS_ENTER && state != PS_ENTER) |-> $past(cnt) == '0);
    assert_sleep_via_enter_R3: assert property (@(posedge clk) disable iff (rst)
        (state == PS_ASLEEP && $past(state) != PS_ASLEEP) |-> $past(state) == PS_ENTER);
    assert_awake_via_wake_R4: assert property (@(posedge clk) disable iff (rst)
        (state == PS_AWAKE && $past(state) != PS_AWAKE) |-> ($past(state) == PS_WAKE && $past(cnt) == '0));
    assert_wake_needs_drop_R4: assert property (@(posedge clk) disable iff (rst)
        (state == PS_WAKE && $past(state) == PS_ASLEEP) |-> !$past(req_i));
endmodule

// File: rtl/pdn_guard.sv
module pdn_guard (
    input  logic clk,
    input  logic rst,
    input  logic block_i,
    input  logic sel_i,
    input  logic stb_a_i,
    input  logic stb_b_i,
    output logic viol_o
);
    logic attempt;
    logic viol_q;

    assign attempt = sel_i | stb_a_i | stb_b_i;

    always_ff @(posedge clk) begin
        if (rst) viol_q <= 1'b0;
        else     viol_q <= block_i & attempt;
    end

    assign viol_o = viol_q;

    assert_viol_cause_R7: assert property (@(posedge clk) disable iff (rst)
        viol_o |-> ($past(block_i) && ($past(sel_i) || $past(stb_a_i) || $past(stb_b_i))));
    assert_no_viol_open_R8: assert property (@(posedge clk) disable iff (rst)
        !$past(block_i) |-> !viol_o);
endmodule

// File: rtl/pdn_sequencer.sv
module pdn_sequencer
    import pdn_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int ENTRY_CYC   = 2,
    parameter int EXIT_CYC    = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pdn_req_async,
    input  logic sel_active,
    input  logic strobe_a,
    input  logic strobe_b,
    output logic sleep_o,
    output logic access_block_o,
    output logic out_disable_o,
    output logic violation_o
);
    logic        req_s;
    pdn_state_e  st;
    pdn_status_t stat;

    pdn_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk(clk), .rst(rst), .d_async(pdn_req_async), .q_sync(req_s)
    );

    pdn_fsm #(.ENTRY_CYC(ENTRY_CYC), .EXIT_CYC(EXIT_CYC)) i_fsm (
        .clk(clk), .rst(rst), .req_i(req_s), .state_o(st)
    );

    assign stat = decode_status(st, req_s);

    pdn_guard i_guard (
        .clk(clk), .rst(rst), .block_i(stat.block),
        .sel_i(sel_active), .stb_a_i(strobe_a), .stb_b_i(strobe_b),
        .viol_o(violation_o)
    );

    assign sleep_o        = stat.sleep;
    assign access_block_o = stat.block;
    assign out_disable_o  = stat.odis;

    assert_sleep_gated_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(sleep_o) |-> $past(out_disable_o));
    assert_block_before_sleep_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(sleep_o) |-> $past(access_block_o));
endmodule

// File: tb/test_pdn_sequencer.sv
module test_pdn_sequencer;
    localparam int SYNC = 2;
    localparam int ENT  = 2;
    localparam int EXT  = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic zz = 1'b0, sel = 1'b0, sa = 1'b0, sb = 1'b0;
    logic sleep_o, blk_o, odis_o, viol_o;

    int checks = 0, fails = 0, cyc = 0;
    string tag = "R1";

    always #2.5 clk = ~clk;

    pdn_sequencer #(.SYNC_STAGES(SYNC), .ENTRY_CYC(ENT), .EXIT_CYC(EXT)) i_pdn_sequencer (
        .clk(clk), .rst(rst), .pdn_req_async(zz), .sel_active(sel),
        .strobe_a(sa), .strobe_b(sb), .sleep_o(sleep_o),
        .access_block_o(blk_o), .out_disable_o(odis_o), .violation_o(viol_o)
    );

    // Reference: phase 0 awake, 1 entering, 2 asleep, 3 recovering
    int hist[$];
    int phase = 0, left = 0, m_viol = 0;

    function automatic int seen_req();
        return hist[SYNC-1];
    endfunction

    initial for (int i = 0; i < SYNC; i++) hist.push_back(0);

    always @(posedge clk) begin
        int rq, blocked, act;
        if (rst) begin
            foreach (hist[i]) hist[i] = 0;
            phase = 0; left = 0; m_viol = 0;
        end else begin
            rq = seen_req();
            blocked = (phase != 0) || (rq != 0);
            act = (sel || sa || sb) ? 1 : 0;
            m_viol = (blocked != 0 && act != 0) ? 1 : 0;
            if (phase == 0) begin
                if (rq != 0) begin phase = 1; left = ENT; end
            end else if (phase == 1) begin
                left--; if (left == 0) phase = 2;
            end else if (phase == 2) begin
                if (rq == 0) begin phase = 3; left = EXT; end
            end else begin
                left--; if (left == 0) phase = 0;
            end
            void'(hist.pop_back());
            hist.push_front(zz ? 1 : 0);
        end
    end

    task automatic chk(input string what, input logic got, input int exp);
        checks++;
        if (int'(got) != exp) begin
            fails++;
            $display("FAIL %s %s: got %0d expected %0d (cycle %0d)", tag, what, got, exp, cyc);
        end
    endtask

    task automatic compare_all();
        chk("sleep_o (R3/R4)", sleep_o, (phase == 2) ? 1 : 0);
        chk("access_block_o (R6)", blk_o, (phase != 0 || seen_req() != 0) ? 1 : 0);
        chk("out_disable_o (R5)", odis_o, (phase != 0) ? 1 : 0);
        chk("violation_o (R7/R8)", viol_o, m_viol);
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    task automatic attempt(input int which);
        sel = (which == 0); sa = (which == 1); sb = (which == 2);
        tick();
        sel = 0; sa = 0; sb = 0;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            fails++;
            $display("FAIL watchdog (all) cycles: got %0d expected below 20000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        int n;
        // R1: reset state
        @(negedge clk);
        tag = "R1";
        chk("sleep_o", sleep_o, 0); chk("access_block_o", blk_o, 0);
        chk("out_disable_o", odis_o, 0); chk("violation_o", viol_o, 0);
        @(negedge clk); rst = 1'b0;
        tick();

        // R8: activity while awake
        tag = "R8";
        for (int k = 0; k < 3; k++) attempt(k);
        tick();

        // R2 + R3: request rises; count edges to block and to sleep
        tag = "R2";
        zz = 1'b1;
        n = 0;
        while (!blk_o && n < 20) begin tick(); n++; end
        chk("edges request->block", 1'(n == SYNC), 1);
        tag = "R3";
        n = 0;
        attempt(0);  // R7: attempt during entry
        n++;
        while (!sleep_o && n < 20) begin tick(); n++; end
        chk("edges block->sleep", 1'(n == ENT + 1), 1);

        // R7: attempts while asleep, each strobe alone
        tag = "R7";
        for (int k = 0; k < 3; k++) begin attempt(k); tick(); end
        chk("sleep held after attempts", sleep_o, 1);

        // R4: request falls; count edges to block release, attempt while recovering
        tag = "R4";
        zz = 1'b0;
        n = 0;
        while (odis_o != 1'b0 || n == 0) begin
            if (n == SYNC + 1) attempt(1); else tick();
            n++;
            if (n > 30) break;
        end
        chk("edges drop->release", 1'(n == SYNC + 1 + EXT), 1);
        chk("access_block_o released", blk_o, 0);
        tick(); tick();

        // R9: drop request right after entry starts
        tag = "R9";
        zz = 1'b1;
        while (!blk_o) tick();
        tick();
        zz = 1'b0;
        n = 0;
        while (!sleep_o && n < 20) begin tick(); n++; end
        chk("sleep reached despite drop", sleep_o, 1);
        while (odis_o) tick();
        chk("back awake", blk_o, 0);
        tick();

        // R10: request returns during recovery
        tag = "R10";
        zz = 1'b1;
        while (!sleep_o) tick();
        zz = 1'b0;
        while (phase != 3) tick();
        zz = 1'b1;
        n = 0;
        while (odis_o && n < 20) begin tick(); n++; end
        chk("awake after full recovery", odis_o, 0);
        tick();
        chk("re-entry after one awake cycle", odis_o, 1);
        for (int k = 0; k < 6; k++) tick();
        chk("asleep again", sleep_o, 1);
        zz = 1'b0;
        for (int k = 0; k < 10; k++) tick();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule